// File: doc/BRIEF.md
# Dot-Matrix Display Controller Register Bank

This block holds the control state of a dot-matrix display controller: seven on/off controls (display enable, inverse video, reversed segment order, read-modify-write mode, booster enable, static drive, driver output enable), the column, start-line and page addresses, the contrast value, and the duty, bias, booster-multiplier and n-line inversion settings. A write strobe with a 5-bit register select and an 8-bit data byte updates one register per cycle. A combinational readback port returns any register. A small serial receive shift register sits beside the bank.

Two initialisation paths exist. The active-low reset pin is first passed through a two-flop synchroniser. A low pulse is accepted only if it lasts longer than a minimum width derived from the clock frequency (10 µs). While an accepted reset is held, every register is forced to its default. After the pin rises, the `busy` output stays high for a 1 µs recovery window. A reset command, written through the ordinary write path, restores only the address, contrast, duty, bias, booster-multiplier and inversion registers.

Top module: `dispctl_regbank`

## Requirements
- R1: An accepted pin reset clears all seven control flags (`ctrl_flags` = 0; readback select 0) and clears the serial shift register (readback select 9).
- R2: An accepted pin reset sets the following registers. Column address (select 1) = 0. Start line (select 2) = 0. Page (select 3) = 0. Contrast (select 4) = 0xFF. Duty code (select 5) = 7, the full-duty setting. Bias code (select 6) = 0, the 1/10 setting. Booster code (select 7) = 2, the 5x setting. n-line count (select 8) = 0.
- R3: A write to select 31, with any data, restores the eight registers of R2 to their R2 values. It leaves the control flags and the serial shift register unchanged.
- R4: A write stores the low bits of the data byte, zero-extended on readback. Select 0 stores the flags in bits 6:0 (bit0 display on, bit1 inverse, bit2 segment reverse, bit3 read-modify-write, bit4 booster on, bit5 static drive, bit6 driver outputs on). Select 1 stores column bits 7:0. Select 2 stores start line bits 6:0. Select 3 stores page bits 3:0. Select 4 stores contrast bits 7:0. Select 5 stores duty bits 2:0. Select 6 stores bias bits 2:0. Select 7 stores booster bits 1:0. Select 8 stores n-line bits 4:0.
- R5: A reset pin low pulse lasting MIN_LOW_CYC core cycles or fewer (500 at defaults) is ignored: no register changes and `busy` stays low.
- R6: `busy` is high while an accepted reset is held. It stays high for RECOV_CYC cycles (50 at defaults) after the synchronised pin returns high, then falls.
- R7: While `busy` is high, register writes, the reset command and serial shifts are ignored.
- R8: Writes to selects 9 to 30 change no register, and those selects other than 9 read back 0.
- R9: When `ser_shift` is high, the serial register shifts left and `ser_bit` enters bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select for writes |
| wr_data | input | 8 | Write data |
| ser_shift | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial input bit |
| rd_sel | input | 5 | Readback select |
| rd_data | output | 8 | Readback data |
| busy | output | 1 | Reset hold or recovery in progress |
| ctrl_flags | output | 7 | Control flags (layout of R4) |
| col_addr | output | 8 | Column address |
| start_line | output | 7 | Display start line |
| page_addr | output | 4 | Page address |
| contrast | output | 8 | Contrast value |
| duty_sel | output | 3 | Duty code |
| bias_sel | output | 3 | Bias code |
| boost_mult | output | 2 | Booster multiplier code |
| nline_cnt | output | 5 | n-line inversion count |

## Verification
The assertions check several things on every cycle. Once busy is high, the flags, contrast, column address and serial register stay frozen. An accepted reset is always followed by a busy recovery period. A reset command leaves the flags and the serial register untouched and restores contrast and duty. Writes to unused selects change nothing. Other behaviour only the bench's directed scenarios can show: the exact default values after a pin reset, the zero-extended field masking of each write, the short-pulse rejection at and below the width limit, and the length of the recovery window measured from the pin's rising edge.

// File: rtl/dispctl_regbank.sv
module dispctl_regbank #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int RST_MIN_NS = 10_000,
  parameter int RECOVER_NS = 1_000
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       wr_en,
  input  logic [4:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       ser_shift,
  input  logic       ser_bit,
  input  logic [4:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic [6:0] ctrl_flags,
  output logic [7:0] col_addr,
  output logic [6:0] start_line,
  output logic [3:0] page_addr,
  output logic [7:0] contrast,
  output logic [2:0] duty_sel,
  output logic [2:0] bias_sel,
  output logic [1:0] boost_mult,
  output logic [4:0] nline_cnt
);
  localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
  localparam int MIN_LOW_CYC = CYC_PER_US * RST_MIN_NS / 1000;
  localparam int RECOV_CYC   = CYC_PER_US * RECOVER_NS / 1000;
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam int RW = $clog2(RECOV_CYC + 1);

  localparam logic [4:0] SEL_FLAGS = 5'd0, SEL_COL = 5'd1, SEL_LINE = 5'd2,
                         SEL_PAGE = 5'd3, SEL_CTR = 5'd4, SEL_DUTY = 5'd5,
                         SEL_BIAS = 5'd6, SEL_BOOST = 5'd7, SEL_NLINE = 5'd8,
                         SEL_SER = 5'd9, SEL_RESET = 5'd31;

  localparam logic [7:0] CTR_DEF   = 8'hFF;
  localparam logic [2:0] DUTY_DEF  = 3'd7;
  localparam logic [2:0] BIAS_DEF  = 3'd0;
  localparam logic [1:0] BOOST_DEF = 2'd2;

  logic          pin_s1, pin_s2;
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic [7:0]    ser_q;
  logic          hold;

  always_ff @(posedge clk) begin
    pin_s1 <= rst_pin_n;
    pin_s2 <= pin_s1;
  end

  always_ff @(posedge clk) begin
    if (pin_s2)
      low_cnt <= '0;
    else if (low_cnt != LW'(MIN_LOW_CYC))
      low_cnt <= low_cnt + 1'b1;
  end

  assign hold = !pin_s2 && (low_cnt == LW'(MIN_LOW_CYC));

  always_ff @(posedge clk) begin
    if (hold)
      rec_cnt <= RW'(RECOV_CYC);
    else if (rec_cnt != '0)
      rec_cnt <= rec_cnt - 1'b1;
  end

  assign busy = hold || (rec_cnt != '0);

  wire wr_ok  = wr_en && !busy;
  wire cmd_rs = wr_ok && (wr_sel == SEL_RESET);

  always_ff @(posedge clk) begin
    if (hold) begin
      ctrl_flags <= '0;
      ser_q      <= '0;
    end else begin
      if (wr_ok && wr_sel == SEL_FLAGS) ctrl_flags <= wr_data[6:0];
      if (ser_shift && !busy)           ser_q      <= {ser_q[6:0], ser_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (hold || cmd_rs) begin
      col_addr   <= '0;
      start_line <= '0;
      page_addr  <= '0;
      contrast   <= CTR_DEF;
      duty_sel   <= DUTY_DEF;
      bias_sel   <= BIAS_DEF;
      boost_mult <= BOOST_DEF;
      nline_cnt  <= '0;
    end else if (wr_ok) begin
      case (wr_sel)
        SEL_COL:   col_addr   <= wr_data;
        SEL_LINE:  start_line <= wr_data[6:0];
        SEL_PAGE:  page_addr  <= wr_data[3:0];
        SEL_CTR:   contrast   <= wr_data;
        SEL_DUTY:  duty_sel   <= wr_data[2:0];
        SEL_BIAS:  bias_sel   <= wr_data[2:0];
        SEL_BOOST: boost_mult <= wr_data[1:0];
        SEL_NLINE: nline_cnt  <= wr_data[4:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_FLAGS: rd_data = {1'b0, ctrl_flags};
      SEL_COL:   rd_data = col_addr;
      SEL_LINE:  rd_data = {1'b0, start_line};
      SEL_PAGE:  rd_data = {4'b0, page_addr};
      SEL_CTR:   rd_data = contrast;
      SEL_DUTY:  rd_data = {5'b0, duty_sel};
      SEL_BIAS:  rd_data = {5'b0, bias_sel};
      SEL_BOOST: rd_data = {6'b0, boost_mult};
      SEL_NLINE: rd_data = {3'b0, nline_cnt};
      SEL_SER:   rd_data = ser_q;
      default:   rd_data = 8'h00;
    endcase
  end

  a_r7_busy_freeze: assert property (@(posedge clk) disable iff (hold)
    busy |=> ($stable(ctrl_flags) && $stable(contrast) && $stable(col_addr) && $stable(ser_q)));

  a_r3_cmd_keeps_flags: assert property (@(posedge clk) disable iff (hold)
    (wr_en && !busy && wr_sel == SEL_RESET && !ser_shift) |=> ($stable(ctrl_flags) && $stable(ser_q)));

  a_r3_cmd_restores: assert property (@(posedge clk) disable iff (hold)
    (wr_en && !busy && wr_sel == SEL_RESET) |=> (contrast == CTR_DEF && duty_sel == DUTY_DEF && boost_mult == BOOST_DEF));

  a_r6_recovery_busy: assert property (@(posedge clk) disable iff (hold)
    $past(hold) |-> busy);

  a_r8_unused_sel: assert property (@(posedge clk) disable iff (hold)
    (wr_en && !busy && wr_sel > SEL_NLINE && wr_sel != SEL_RESET) |=>
      ($stable(ctrl_flags) && $stable(contrast) && $stable(col_addr) && $stable(nline_cnt)));
endmodule

// File: tb/dispctl_regbank_tb.sv
module dispctl_regbank_tb_top;
  localparam int MIN_LOW = 500;
  localparam int RECOV   = 50;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic ser_shift = 1'b0, ser_bit = 1'b0;
  logic [4:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic busy;
  logic [6:0] ctrl_flags;
  logic [7:0] col_addr, contrast;
  logic [6:0] start_line;
  logic [3:0] page_addr;
  logic [2:0] duty_sel, bias_sel;
  logic [1:0] boost_mult;
  logic [4:0] nline_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dispctl_regbank dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ser_shift(ser_shift), .ser_bit(ser_bit), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy), .ctrl_flags(ctrl_flags), .col_addr(col_addr), .start_line(start_line),
    .page_addr(page_addr), .contrast(contrast), .duty_sel(duty_sel), .bias_sel(bias_sel),
    .boost_mult(boost_mult), .nline_cnt(nline_cnt));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] sel, input logic [7:0] exp);
    @(negedge clk);
    rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [4:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pin_pulse(input int width);
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (width) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_defaults(input string tag);
    rd_chk({tag, " col"}, 5'd1, 8'h00);
    rd_chk({tag, " line"}, 5'd2, 8'h00);
    rd_chk({tag, " page"}, 5'd3, 8'h00);
    rd_chk({tag, " contrast"}, 5'd4, 8'hFF);
    rd_chk({tag, " duty"}, 5'd5, 8'h07);
    rd_chk({tag, " bias"}, 5'd6, 8'h00);
    rd_chk({tag, " boost"}, 5'd7, 8'h02);
    rd_chk({tag, " nline"}, 5'd8, 8'h00);
  endtask

  task automatic t_power_reset();
    pin_pulse(MIN_LOW + 100);
    wait_cyc(RECOV + 10);
    chk("R6 busy low after recovery", busy, 0);
    rd_chk("R1 flags", 5'd0, 8'h00);
    chk("R1 flag port", ctrl_flags, 0);
    rd_chk("R1 serial", 5'd9, 8'h00);
    check_defaults("R2");
    chk("R2 contrast port", contrast, 8'hFF);
  endtask

  task automatic t_writes();
    wr(5'd0, 8'hFF);
    wr(5'd1, 8'h83);
    wr(5'd2, 8'hFF);
    wr(5'd3, 8'hAB);
    wr(5'd4, 8'h3C);
    wr(5'd5, 8'hFD);
    wr(5'd6, 8'h0E);
    wr(5'd7, 8'h03);
    wr(5'd8, 8'hFF);
    rd_chk("R4 flags", 5'd0, 8'h7F);
    rd_chk("R4 col", 5'd1, 8'h83);
    rd_chk("R4 line", 5'd2, 8'h7F);
    rd_chk("R4 page", 5'd3, 8'h0B);
    rd_chk("R4 contrast", 5'd4, 8'h3C);
    rd_chk("R4 duty", 5'd5, 8'h05);
    rd_chk("R4 bias", 5'd6, 8'h06);
    rd_chk("R4 boost", 5'd7, 8'h03);
    rd_chk("R4 nline", 5'd8, 8'h1F);
    chk("R4 page port", page_addr, 4'hB);
  endtask

  task automatic t_serial();
    bit [7:0] pat = 8'hB2;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ser_shift = 1'b1; ser_bit = pat[i];
    end
    @(negedge clk);
    ser_shift = 1'b0;
    rd_chk("R9 serial word", 5'd9, 8'hB2);
  endtask

  task automatic t_unused();
    wr(5'd12, 8'h55);
    wr(5'd9, 8'h00);
    wr(5'd30, 8'hAA);
    rd_chk("R8 sel12 reads zero", 5'd12, 8'h00);
    rd_chk("R8 serial unchanged", 5'd9, 8'hB2);
    rd_chk("R8 contrast unchanged", 5'd4, 8'h3C);
    rd_chk("R8 col unchanged", 5'd1, 8'h83);
    rd_chk("R8 flags unchanged", 5'd0, 8'h7F);
  endtask

  task automatic t_cmd_reset();
    wr(5'd31, 8'h5A);
    check_defaults("R3");
    rd_chk("R3 flags kept", 5'd0, 8'h7F);
    rd_chk("R3 serial kept", 5'd9, 8'hB2);
  endtask

  task automatic t_short();
    bit saw_busy = 1'b0;
    wr(5'd4, 8'h44);
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (400) begin @(negedge clk); if (busy) saw_busy = 1'b1; end
    rst_pin_n = 1'b1;
    repeat (RECOV + 10) begin @(negedge clk); if (busy) saw_busy = 1'b1; end
    chk("R5 400-cycle pulse no busy", saw_busy, 0);
    rd_chk("R5 contrast kept", 5'd4, 8'h44);
    saw_busy = 1'b0;
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (MIN_LOW) begin @(negedge clk); if (busy) saw_busy = 1'b1; end
    rst_pin_n = 1'b1;
    repeat (RECOV + 10) begin @(negedge clk); if (busy) saw_busy = 1'b1; end
    chk("R5 limit pulse no busy", saw_busy, 0);
    rd_chk("R5 contrast kept at limit", 5'd4, 8'h44);
    rd_chk("R5 flags kept at limit", 5'd0, 8'h7F);
    rd_chk("R5 serial kept at limit", 5'd9, 8'hB2);
  endtask

  task automatic t_accept_busy();
    pin_pulse(MIN_LOW + 2);
    wait_cyc(1);
    chk("R6 busy right after release", busy, 1);
    wait_cyc(4);
    chk("R6 busy in recovery", busy, 1);
    wr(5'd4, 8'h12);
    wr(5'd0, 8'h01);
    wr(5'd31, 8'h00);
    @(negedge clk);
    ser_shift = 1'b1; ser_bit = 1'b1;
    @(negedge clk);
    ser_shift = 1'b0;
    wait_cyc(RECOV + 10);
    chk("R6 busy falls", busy, 0);
    rd_chk("R7 contrast write ignored", 5'd4, 8'hFF);
    rd_chk("R7 flags write ignored", 5'd0, 8'h00);
    rd_chk("R7 shift ignored", 5'd9, 8'h00);
    rd_chk("R1 flags cleared by limit+2 pulse", 5'd0, 8'h00);
  endtask

  task automatic t_hold_writes();
    @(negedge clk);
    rst_pin_n = 1'b0;
    wait_cyc(MIN_LOW + 20);
    chk("R6 busy while held", busy, 1);
    wr(5'd1, 8'h21);
    chk("R7 col write ignored while held", col_addr, 0);
    rst_pin_n = 1'b1;
    wait_cyc(RECOV + 10);
    rd_chk("R7 col after hold", 5'd1, 8'h00);
  endtask

  initial begin
    t_power_reset();
    t_writes();
    t_serial();
    t_unused();
    t_cmd_reset();
    t_short();
    t_accept_busy();
    t_hold_writes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule